// File: doc/BRIEF.md
# General-Purpose Pin Register File

This block is the control register file for a bank of 50 general-purpose pins. Software reaches it through a simple 16-bit single-cycle bus: a select strobe, a write flag, a byte address and write data. It holds the output latches of every pin and the direction bits of the lower pins. Reading a data register returns, for each pin, either the latch (when the pin drives) or the synchronised pad value (when it listens). The outputs are levels that go straight to pad control: one output enable and one output value per pin, and for the fifteen lowest pins a pull enable and a pull-up qualifier.

The pins fall into four banks of up to sixteen. Pins 0–31 have full direction control. Pins 32–47 are output-only and always drive. The two top pins, 48 and 49, have no direction register of their own: their enables sit in the upper half of the register that holds their data bits. A separate pair of registers controls pull resistors on pins 0–14. One register turns the pull on, and the other chooses pull-up or pull-down.

Every register is 16 bits wide. Each register has a fixed write mask, so bits that carry no function always read as zero and ignore writes. The pad drivers, analog pulls and interrupt logic lie outside this block.

Top module: `gpio_rf`

## Requirements
- R1: After reset every register is zero. So pin_out, pull_en and pull_up are all zero, pin_oe is zero for pins 0–31 and 48–49, and pin_oe is one for the output-only pins 32–47.
- R2: A write to offset 0x000 (pins 0–15) or 0x002 (pins 16–31) sets the direction bits, with bit i belonging to pin base+i. A 1 drives pin_oe high (output) and a 0 sets it low (input).
- R3: Writes to offsets 0x004, 0x006 and 0x01C set the output latches of pins 0–15, 16–31 and 32–47, with bit i for pin base+i, and the latches appear on pin_out. Pins 32–47 always have pin_oe high.
- R4: In offset 0x01E, bits 0 and 1 are the output latches of pins 48 and 49, and bits 8 and 9 are their output enables. All other bits of that register read zero and ignore writes.
- R5: Reading a data register (0x004, 0x006, 0x01C, or bits 0–1 of 0x01E) returns, for each pin, the latch when its output enable is 1 and pad_in when it is 0.
- R6: Offset 0x1E0 holds the pull-enable bits and offset 0x1E2 holds the pull-up select bits for pins 0–14, with bit i for pin i. pull_en equals the enable bit. pull_up is 1 only when both the enable bit and the select bit are set (1 means up, 0 means down). Bit 15 of both registers reads zero and ignores writes.
- R7: An access to any other offset, including odd offsets, reads zero and changes no register.
- R8: Read data appears on bus_rdata in the cycle after the access and is zero in every cycle that does not follow a read. A write changes the outputs from the clock edge that samples it, and the outputs hold in every cycle without a write.
- R9: Reading the direction and pull registers returns the last value written under their write masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (10) | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the access |
| pad_in | input | 50 | Synchronised pad input values |
| pin_oe | output | 50 | Per-pin output enable |
| pin_out | output | 50 | Per-pin output value |
| pull_en | output | 15 | Pull resistor enable, pins 0–14 |
| pull_up | output | 15 | Pull-up selected and enabled, pins 0–14 |

## Verification
A write sampled at a rising edge changes pin_oe, pin_out, pull_en and pull_up right after that edge, so the bench checks those ports at the falling edge that follows. Read data passes through one output register and is due one full cycle after the access. The driver queues the expected word when it issues a read. The monitor records that a read was sampled at a rising edge and pops and compares the queued word at the next falling edge. This keeps every comparison half a cycle clear of the edge that updates it.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;

    localparam int DW        = 16;  // bus and register width
    localparam int TOP_PINS  = 2;   // pins in the uppermost bank
    localparam int NUM_PINS  = 3 * DW + TOP_PINS;
    localparam int PULL_PINS = 15;  // pins with pull control
    localparam int OE_LSB    = 8;   // enable field of the top bank
    localparam int NREG      = 8;

    typedef enum int {
        RG_DIR0 = 0,
        RG_DIR1 = 1,
        RG_DAT0 = 2,
        RG_DAT1 = 3,
        RG_DAT2 = 4,
        RG_DAT3 = 5,
        RG_PUSE = 6,
        RG_PSEL = 7
    } reg_id_e;

    function automatic logic [9:0] reg_offset(input int idx);
        case (idx)
            RG_DIR0: return 10'h000;
            RG_DIR1: return 10'h002;
            RG_DAT0: return 10'h004;
            RG_DAT1: return 10'h006;
            RG_DAT2: return 10'h01C;
            RG_DAT3: return 10'h01E;
            RG_PUSE: return 10'h1E0;
            default: return 10'h1E2;
        endcase
    endfunction

    function automatic logic [DW-1:0] reg_wmask(input int idx);
        logic [DW-1:0] m;
        m = '1;
        if (idx == RG_DAT3) begin
            m = '0;
            m[TOP_PINS-1:0]               = '1;
            m[OE_LSB +: TOP_PINS]         = '1;
        end else if (idx == RG_PUSE || idx == RG_PSEL) begin
            m = '0;
            m[PULL_PINS-1:0]              = '1;
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_rf_decode.sv
module gpio_rf_decode
    import gpio_rf_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   hit
);

    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = (addr == ADDR_W'(reg_offset(i)));
    end

endmodule

// File: rtl/gpio_rf_reg.sv
module gpio_rf_reg #(
    parameter int           W     = 16,
    parameter logic [W-1:0] WMASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (wr) begin
            val_d = (val_q & ~WMASK) | (wdata & WMASK);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign q = val_q;

endmodule

// File: rtl/gpio_rf_rdmux.sv
module gpio_rf_rdmux
    import gpio_rf_pkg::*;
(
    input  logic [NREG-1:0]         hit,
    input  logic [NREG-1:0][DW-1:0] regs,
    input  logic [NUM_PINS-1:0]     oe,
    input  logic [NUM_PINS-1:0]     latch,
    input  logic [NUM_PINS-1:0]     pad,
    output logic [DW-1:0]           rdata
);

    logic [NUM_PINS-1:0]     pin_val;
    logic [NREG-1:0][DW-1:0] view;

    // driving pins report their latch, listening pins report the pad
    assign pin_val = (oe & latch) | (~oe & pad);

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            view[i] = regs[i];
        end
        view[RG_DAT0] = pin_val[0 +: DW];
        view[RG_DAT1] = pin_val[DW +: DW];
        view[RG_DAT2] = pin_val[2*DW +: DW];
        view[RG_DAT3] = '0;
        view[RG_DAT3][TOP_PINS-1:0]       = pin_val[3*DW +: TOP_PINS];
        view[RG_DAT3][OE_LSB +: TOP_PINS] = oe[3*DW +: TOP_PINS];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                rdata = rdata | view[i];
            end
        end
    end

endmodule

// File: rtl/gpio_rf.sv
module gpio_rf
    import gpio_rf_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NUM_PINS-1:0]  pad_in,
    output logic [NUM_PINS-1:0]  pin_oe,
    output logic [NUM_PINS-1:0]  pin_out,
    output logic [PULL_PINS-1:0] pull_en,
    output logic [PULL_PINS-1:0] pull_up
);

    typedef struct packed {
        logic [DW-1:0] rdata;
    } top_state_t;

    top_state_t              st_d, st_q;
    logic [NREG-1:0]         hit;
    logic [NREG-1:0][DW-1:0] reg_q;
    logic [DW-1:0]           mux_rdata;

    gpio_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .hit  (hit)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        gpio_rf_reg #(
            .W     (DW),
            .WMASK (reg_wmask(i))
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (bus_sel && bus_we && hit[i]),
            .wdata (bus_wdata),
            .q     (reg_q[i])
        );
    end

    assign pin_oe  = {reg_q[RG_DAT3][OE_LSB +: TOP_PINS], {DW{1'b1}},
                      reg_q[RG_DIR1], reg_q[RG_DIR0]};
    assign pin_out = {reg_q[RG_DAT3][TOP_PINS-1:0], reg_q[RG_DAT2],
                      reg_q[RG_DAT1], reg_q[RG_DAT0]};
    assign pull_en = reg_q[RG_PUSE][PULL_PINS-1:0];
    assign pull_up = reg_q[RG_PUSE][PULL_PINS-1:0]
                   & reg_q[RG_PSEL][PULL_PINS-1:0];

    gpio_rf_rdmux u_mux (
        .hit   (hit),
        .regs  (reg_q),
        .oe    (pin_oe),
        .latch (pin_out),
        .pad   (pad_in),
        .rdata (mux_rdata)
    );

    always_comb begin
        st_d = '0;
        if (bus_sel && !bus_we) begin
            st_d.rdata = mux_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/gpio_rf_chk.sv
module gpio_rf_chk
    import gpio_rf_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DW-1:0]        bus_wdata,
    input logic [DW-1:0]        bus_rdata,
    input logic [NUM_PINS-1:0]  pin_oe,
    input logic [NUM_PINS-1:0]  pin_out,
    input logic [PULL_PINS-1:0] pull_en,
    input logic [PULL_PINS-1:0] pull_up
);

    logic wr_at;
    assign wr_at = bus_sel && bus_we;

    p_dir_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_at && bus_addr == ADDR_W'(10'h000)
        |=> pin_oe[DW-1:0] == $past(bus_wdata));

    p_latch_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_at && bus_addr == ADDR_W'(10'h004)
        |=> pin_out[DW-1:0] == $past(bus_wdata));

    p_top_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_at && bus_addr == ADDR_W'(10'h01E)
        |=> pin_oe[NUM_PINS-1 -: TOP_PINS] == $past(bus_wdata[OE_LSB +: TOP_PINS])
            && pin_out[NUM_PINS-1 -: TOP_PINS] == $past(bus_wdata[TOP_PINS-1:0]));

    p_pull_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_at && bus_addr == ADDR_W'(10'h1E0)
        |=> pull_en == $past(bus_wdata[PULL_PINS-1:0]));

    p_pull_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_up & ~pull_en) == '0);

    p_rdata_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> bus_rdata == '0);

    p_hold_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_at |=> $stable(pin_oe) && $stable(pin_out)
                   && $stable(pull_en) && $stable(pull_up));

endmodule

bind gpio_rf gpio_rf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .pull_en   (pull_en),
    .pull_up   (pull_up)
);

// File: tb/gpio_rf_test.sv
`timescale 1ns/1ps
module gpio_rf_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [49:0] pad_in = '0;
    logic [49:0] pin_oe, pin_out;
    logic [14:0] pull_en, pull_up;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit rd_pend = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    gpio_rf uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pin_oe(pin_oe), .pin_out(pin_out),
        .pull_en(pull_en), .pull_up(pull_up)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [9:0] a, input logic [15:0] e, input string tag);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    // monitor: a read sampled at a rising edge is compared at the next falling edge
    always @(posedge clk) rd_pend <= rst_n && bus_sel && !bus_we;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected read data", 64'(bus_rdata), 64'hDEAD);
            end else begin
                string t;
                logic [15:0] e;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, 64'(bus_rdata), 64'(e));
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [49:0] e_oe, e_out;
        pad_in = {2'b01, 16'h7777, 16'hC33C, 16'h5AA5};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin_oe", 64'(pin_oe), 64'({2'b00, 16'hFFFF, 32'h0}));
        chk("R1 pin_out", 64'(pin_out), 64'h0);
        chk("R1 pull_en", 64'(pull_en), 64'h0);
        chk("R1 pull_up", 64'(pull_up), 64'h0);
        chk("R1 rdata", 64'(bus_rdata), 64'h0);
        rd(10'h000, 16'h0000, "R1 direction reads zero");

        // R2 direction, R3 latches, R5 mixed read-back
        wr(10'h000, 16'h00FF);
        chk("R2 pin_oe low bank", 64'(pin_oe[15:0]), 64'h00FF);
        wr(10'h004, 16'hA5C3);
        chk("R3 pin_out low bank", 64'(pin_out[15:0]), 64'hA5C3);
        rd(10'h004, 16'h5AC3, "R5 low bank mixed");
        wr(10'h002, 16'hF0F0);
        chk("R2 pin_oe bank1", 64'(pin_oe[31:16]), 64'hF0F0);
        wr(10'h006, 16'h1234);
        chk("R3 pin_out bank1", 64'(pin_out[31:16]), 64'h1234);
        rd(10'h006, 16'h133C, "R5 bank1 mixed");
        rd(10'h002, 16'hF0F0, "R9 direction read-back");

        wr(10'h01C, 16'hBEEF);
        chk("R3 pin_out bank2", 64'(pin_out[47:32]), 64'hBEEF);
        chk("R3 bank2 always driven", 64'(pin_oe[47:32]), 64'hFFFF);
        rd(10'h01C, 16'hBEEF, "R5 bank2 reads latch");

        // R4 top pair
        wr(10'h01E, 16'hFFFF);
        chk("R4 top oe", 64'(pin_oe[49:48]), 64'h3);
        chk("R4 top out", 64'(pin_out[49:48]), 64'h3);
        rd(10'h01E, 16'h0303, "R4 top register masked");
        wr(10'h01E, 16'h0102);
        chk("R4 top oe split", 64'(pin_oe[49:48]), 64'h1);
        chk("R4 top out split", 64'(pin_out[49:48]), 64'h2);
        rd(10'h01E, 16'h0100, "R5 top pins latch vs pad");

        // R6 pull control
        wr(10'h1E0, 16'hFFFF);
        chk("R6 pull_en masked", 64'(pull_en), 64'h7FFF);
        chk("R6 pull_up without select", 64'(pull_up), 64'h0);
        rd(10'h1E0, 16'h7FFF, "R9 pull enable read-back");
        wr(10'h1E2, 16'h80F0);
        chk("R6 pull_up selected", 64'(pull_up), 64'h00F0);
        rd(10'h1E2, 16'h00F0, "R6 select bit15 ignored");
        wr(10'h1E0, 16'h0030);
        chk("R6 pull_en reduced", 64'(pull_en), 64'h0030);
        chk("R6 pull_up needs enable", 64'(pull_up), 64'h0030);

        // R7 unmapped offsets
        e_oe  = {2'b01, 16'hFFFF, 16'hF0F0, 16'h00FF};
        e_out = {2'b10, 16'hBEEF, 16'h1234, 16'hA5C3};
        wr(10'h008, 16'hFFFF);
        wr(10'h005, 16'hFFFF);
        wr(10'h1E4, 16'hFFFF);
        chk("R7 pin_oe untouched", 64'(pin_oe), 64'(e_oe));
        chk("R7 pin_out untouched", 64'(pin_out), 64'(e_out));
        chk("R7 pull_en untouched", 64'(pull_en), 64'h0030);
        chk("R7 pull_up untouched", 64'(pull_up), 64'h0030);
        rd(10'h008, 16'h0000, "R7 unmapped read");
        rd(10'h005, 16'h0000, "R7 odd offset read");
        rd(10'h1E4, 16'h0000, "R7 past pull pair read");
        rd(10'h1E2, 16'h00F0, "R7 select kept");

        // R8 idle read data
        @(negedge clk);
        @(negedge clk);
        chk("R8 rdata idle zero", 64'(bus_rdata), 64'h0);
        chk("R8 scoreboard drained", 64'(exp_q.size()), 64'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule